// File: doc/BRIEF.md
# Packed Dual 16-bit Integer ALU

This unit runs one integer operation on two 16-bit lanes packed in each 32-bit operand. The low lane occupies bits [15:0] and the high lane bits [31:16]. Each lane is computed on its own, and no carry, borrow or shift bit crosses between lanes. A 10-bit opcode selects the operation. Two sources feed every operation, and a third source is used only by multiply-add.

The result and an illegal-opcode flag are registered. They appear on the clock edge after the inputs are presented. The opcodes form a contiguous block starting at 0x380. The three shifts take their operands in reversed order: the first source gives a per-lane shift count and the second source gives the data. An opcode outside the block clears the result and raises the flag.

Top module: `pk16_alu`

## Requirements
- R1: Every lane is computed independently. A carry or borrow out of the low lane never changes the high lane.
- R2: Opcodes 0x382 (signed add), 0x38A (unsigned add), 0x383 (signed subtract) and 0x38B (unsigned subtract) compute a+b or a-b per lane, modulo 2^16.
- R3: Opcode 0x381 returns bits [15:0] of the product a*b per lane.
- R4: Opcodes 0x380 (signed) and 0x389 (unsigned) return a*b+c per lane, modulo 2^16.
- R5: Opcodes 0x384 (shift left), 0x385 (logical shift right) and 0x386 (arithmetic shift right) shift the lane of b by bits [3:0] of the matching lane of a. The upper 12 bits of each count lane are ignored.
- R6: Opcodes 0x387 and 0x388 return, per lane, the larger and the smaller value respectively, comparing as two's complement.
- R7: Opcodes 0x38C and 0x38D return, per lane, the larger and the smaller value respectively, comparing as unsigned.
- R8: Any opcode outside 0x380..0x38D sets illegal_o to 1 and result_o to 0. A legal opcode clears illegal_o.
- R9: result_o and illegal_o update on the rising clock edge after the inputs are applied. An active-low asynchronous reset clears both to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 10 | Operation code |
| src_a_i | input | 32 | First source; shift count for shifts |
| src_b_i | input | 32 | Second source; shifted data for shifts |
| src_c_i | input | 32 | Addend for multiply-add |
| result_o | output | 32 | Registered packed result |
| illegal_o | output | 1 | Registered illegal-opcode flag |

## Verification
The hardest case to reach is a lane boundary under stress: the low lane overflows, underflows or produces a product wider than 16 bits, and the high lane must stay untouched. Random operands seldom land on exactly 0xFFFF, 0x8000 or 0x7FFF. The stimulus therefore draws each lane from a pool weighted toward those values and toward 0 and 1. A directed table adds shift counts with stray upper bits and signed-versus-unsigned compares on the same operand pair.

// File: rtl/pk16_pkg.sv
package pk16_pkg;
  localparam int OP_W = 10;

  localparam logic [OP_W-1:0] OP_MAD_S = 10'h380;
  localparam logic [OP_W-1:0] OP_MUL_LO = 10'h381;
  localparam logic [OP_W-1:0] OP_ADD_S = 10'h382;
  localparam logic [OP_W-1:0] OP_SUB_S = 10'h383;
  localparam logic [OP_W-1:0] OP_SHL = 10'h384;
  localparam logic [OP_W-1:0] OP_SHR = 10'h385;
  localparam logic [OP_W-1:0] OP_SRA = 10'h386;
  localparam logic [OP_W-1:0] OP_MAX_S = 10'h387;
  localparam logic [OP_W-1:0] OP_MIN_S = 10'h388;
  localparam logic [OP_W-1:0] OP_MAD_U = 10'h389;
  localparam logic [OP_W-1:0] OP_ADD_U = 10'h38A;
  localparam logic [OP_W-1:0] OP_SUB_U = 10'h38B;
  localparam logic [OP_W-1:0] OP_MAX_U = 10'h38C;
  localparam logic [OP_W-1:0] OP_MIN_U = 10'h38D;

  typedef enum logic [3:0] {
    K_ADD, K_SUB, K_MUL, K_MAD, K_SHL, K_SHR, K_SRA, K_MAX, K_MIN
  } kind_e;

  typedef struct packed {
    kind_e kind;
    logic  sgn;
    logic  legal;
  } ctl_t;
endpackage

// File: rtl/pk16_decode.sv
module pk16_decode
  import pk16_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output ctl_t            ctl_o
);
  always_comb begin
    ctl_o = '{kind: K_ADD, sgn: 1'b0, legal: 1'b1};
    unique case (op_i)
      OP_MAD_S:  begin ctl_o.kind = K_MAD; ctl_o.sgn = 1'b1; end
      OP_MAD_U:  ctl_o.kind = K_MAD;
      OP_MUL_LO: ctl_o.kind = K_MUL;
      OP_ADD_S:  begin ctl_o.kind = K_ADD; ctl_o.sgn = 1'b1; end
      OP_ADD_U:  ctl_o.kind = K_ADD;
      OP_SUB_S:  begin ctl_o.kind = K_SUB; ctl_o.sgn = 1'b1; end
      OP_SUB_U:  ctl_o.kind = K_SUB;
      OP_SHL:    ctl_o.kind = K_SHL;
      OP_SHR:    ctl_o.kind = K_SHR;
      OP_SRA:    ctl_o.kind = K_SRA;
      OP_MAX_S:  begin ctl_o.kind = K_MAX; ctl_o.sgn = 1'b1; end
      OP_MIN_S:  begin ctl_o.kind = K_MIN; ctl_o.sgn = 1'b1; end
      OP_MAX_U:  ctl_o.kind = K_MAX;
      OP_MIN_U:  ctl_o.kind = K_MIN;
      default:   ctl_o.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/pk16_lane.sv
module pk16_lane
  import pk16_pkg::*;
#(
  parameter int LANE_W = 16
) (
  input  kind_e             kind_i,
  input  logic              sgn_i,
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  input  logic [LANE_W-1:0] c_i,
  output logic [LANE_W-1:0] res_o
);
  localparam int SH_W = $clog2(LANE_W);

  logic [LANE_W-1:0] prod;
  logic [SH_W-1:0]   amt;
  logic              a_lt_b;

  assign prod = a_i * b_i;   // low half only; sign does not matter here
  assign amt  = a_i[SH_W-1:0];
  assign a_lt_b = sgn_i ? ($signed(a_i) < $signed(b_i)) : (a_i < b_i);

  always_comb begin
    unique case (kind_i)
      K_ADD:   res_o = a_i + b_i;
      K_SUB:   res_o = a_i - b_i;
      K_MUL:   res_o = prod;
      K_MAD:   res_o = prod + c_i;
      K_SHL:   res_o = b_i << amt;
      K_SHR:   res_o = b_i >> amt;
      K_SRA:   res_o = $unsigned($signed(b_i) >>> amt);
      K_MAX:   res_o = a_lt_b ? b_i : a_i;
      K_MIN:   res_o = a_lt_b ? a_i : b_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/pk16_alu.sv
module pk16_alu
  import pk16_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int LANES  = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [OP_W-1:0]          op_i,
  input  logic [LANE_W*LANES-1:0]  src_a_i,
  input  logic [LANE_W*LANES-1:0]  src_b_i,
  input  logic [LANE_W*LANES-1:0]  src_c_i,
  output logic [LANE_W*LANES-1:0]  result_o,
  output logic                     illegal_o
);
  localparam int DATA_W = LANE_W * LANES;
  localparam int SH_W   = $clog2(LANE_W);

  ctl_t              ctl;
  logic [DATA_W-1:0] lanes_res;
  logic              past_ok;

  pk16_decode u_dec (.op_i(op_i), .ctl_o(ctl));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pk16_lane #(.LANE_W(LANE_W)) u_lane (
      .kind_i(ctl.kind),
      .sgn_i (ctl.sgn),
      .a_i   (src_a_i[g*LANE_W +: LANE_W]),
      .b_i   (src_b_i[g*LANE_W +: LANE_W]),
      .c_i   (src_c_i[g*LANE_W +: LANE_W]),
      .res_o (lanes_res[g*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o  <= '0;
      illegal_o <= 1'b0;
      past_ok   <= 1'b0;
    end else begin
      result_o  <= ctl.legal ? lanes_res : '0;
      illegal_o <= !ctl.legal;
      past_ok   <= 1'b1;
    end
  end

  AST_ILLEGAL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> result_o == '0); // R8

  AST_ILLEGAL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> illegal_o == ($past(op_i) < OP_MAD_S || $past(op_i) > OP_MIN_U)); // R8

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    AST_UMAX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok && $past(op_i) == OP_MAX_U |->
        result_o[g*LANE_W +: LANE_W] >= $past(src_a_i[g*LANE_W +: LANE_W]) &&
        result_o[g*LANE_W +: LANE_W] >= $past(src_b_i[g*LANE_W +: LANE_W])); // R7

    AST_SMIN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok && $past(op_i) == OP_MIN_S |->
        $signed(result_o[g*LANE_W +: LANE_W]) <= $signed($past(src_a_i[g*LANE_W +: LANE_W])) &&
        $signed(result_o[g*LANE_W +: LANE_W]) <= $signed($past(src_b_i[g*LANE_W +: LANE_W]))); // R6

    AST_SHIFT_ZERO_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok && ($past(op_i) == OP_SHL || $past(op_i) == OP_SHR || $past(op_i) == OP_SRA) &&
        $past(src_a_i[g*LANE_W +: SH_W]) == '0 |->
        result_o[g*LANE_W +: LANE_W] == $past(src_b_i[g*LANE_W +: LANE_W])); // R5
  end
endmodule

// File: tb/pk16_alu_bench.sv
`timescale 1ns/1ps
module pk16_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  op = '0;
  logic [31:0] sa = '0, sb = '0, sc = '0;
  logic [31:0] res;
  logic        ill;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pk16_alu u_pk16_alu (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .src_a_i(sa), .src_b_i(sb),
    .src_c_i(sc), .result_o(res), .illegal_o(ill));

  // {op, a, b, c, expected, illegal}
  localparam int NV = 19;
  localparam logic [138:0] VEC [NV] = '{
    {10'h382, 32'h0001FFFF, 32'h00010001, 32'h0, 32'h00020000, 1'b0},
    {10'h38A, 32'h7FFF8000, 32'h00018000, 32'h0, 32'h80000000, 1'b0},
    {10'h383, 32'h00000005, 32'h00010007, 32'h0, 32'hFFFFFFFE, 1'b0},
    {10'h38B, 32'h12345678, 32'h02340678, 32'h0, 32'h10005000, 1'b0},
    {10'h381, 32'h01000003, 32'h01000005, 32'h0, 32'h0000000F, 1'b0},
    {10'h381, 32'hFFFF0002, 32'hFFFF8000, 32'h0, 32'h00010000, 1'b0},
    {10'h380, 32'h00030002, 32'h00040005, 32'h00010001, 32'h000D000B, 1'b0},
    {10'h380, 32'hFFFE0000, 32'h00030000, 32'h00000007, 32'hFFFA0007, 1'b0},
    {10'h389, 32'hFFFF0100, 32'h00020100, 32'h0003FFFF, 32'h0001FFFF, 1'b0},
    {10'h384, 32'h00120004, 32'h00010001, 32'h0, 32'h00040010, 1'b0},
    {10'h385, 32'h000F0001, 32'h80008000, 32'h0, 32'h00014000, 1'b0},
    {10'h386, 32'h000F0004, 32'h80008000, 32'h0, 32'hFFFFF800, 1'b0},
    {10'h387, 32'h8000FFFF, 32'h7FFF0001, 32'h0, 32'h7FFF0001, 1'b0},
    {10'h388, 32'h8000FFFF, 32'h7FFF0001, 32'h0, 32'h8000FFFF, 1'b0},
    {10'h38C, 32'h8000FFFF, 32'h7FFF0001, 32'h0, 32'h8000FFFF, 1'b0},
    {10'h38D, 32'h8000FFFF, 32'h7FFF0001, 32'h0, 32'h7FFF0001, 1'b0},
    {10'h38E, 32'h12345678, 32'h11111111, 32'h0, 32'h00000000, 1'b1},
    {10'h000, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 32'h00000000, 1'b1},
    {10'h37F, 32'h00010001, 32'h00010001, 32'h0, 32'h00000000, 1'b1}
  };

  function automatic string req_of(logic [9:0] o);
    case (o)
      10'h382, 10'h383, 10'h38A, 10'h38B: return "R2";
      10'h381: return "R3";
      10'h380, 10'h389: return "R4";
      10'h384, 10'h385, 10'h386: return "R5";
      10'h387, 10'h388: return "R6";
      10'h38C, 10'h38D: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [15:0] ref_lane(logic [9:0] o, logic [15:0] a, b, c);
    logic [3:0] n = a[3:0];
    case (o)
      10'h380, 10'h389: return 16'(a * b + c);
      10'h381: return 16'(a * b);
      10'h382, 10'h38A: return 16'(a + b);
      10'h383, 10'h38B: return 16'(a - b);
      10'h384: return b << n;
      10'h385: return b >> n;
      10'h386: return 16'($signed(b) >>> n);
      10'h387: return ($signed(a) > $signed(b)) ? a : b;
      10'h388: return ($signed(a) < $signed(b)) ? a : b;
      10'h38C: return (a > b) ? a : b;
      10'h38D: return (a < b) ? a : b;
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [15:0] pick16();
    case ($urandom_range(0, 6))
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'h7FFF;
      3: return 16'h8000;
      4: return 16'hFFFF;
      default: return 16'($urandom);
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run(logic [9:0] o, logic [31:0] a, b, c, logic [31:0] exp, logic e_ill, string req);
    @(negedge clk);
    op = o; sa = a; sb = b; sc = c;
    @(negedge clk);
    chk(req, res, exp);
    chk(req, {31'b0, ill}, {31'b0, e_ill});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R9: reset holds outputs at zero even with an active opcode
    op = 10'h38E; sa = 32'hFFFFFFFF; sb = 32'h1;
    repeat (3) @(negedge clk);
    chk("R9", res, 32'h0);
    chk("R9", {31'b0, ill}, 32'h0);
    rst_n = 1'b1;

    // R9: output reflects inputs only after the next edge
    @(negedge clk);
    op = 10'h382; sa = 32'h00010002; sb = 32'h00030004; sc = '0;
    #1 chk("R9", res, 32'h0);
    @(negedge clk);
    chk("R9", res, 32'h00040006);

    for (int i = 0; i < NV; i++) begin
      logic [138:0] v = VEC[i];
      run(v[138:129], v[128:97], v[96:65], v[64:33], v[32:1], v[0], req_of(v[138:129]));
    end

    // R8: legal opcode after illegal clears the flag
    run(10'h38F, 32'h1, 32'h1, 32'h0, 32'h0, 1'b1, "R8");
    run(10'h38A, 32'h00010001, 32'h00010001, 32'h0, 32'h00020002, 1'b0, "R8");

    // R1: low-lane borrow/overflow must not reach the high lane
    run(10'h38B, 32'h55550000, 32'h00000001, 32'h0, 32'h5555FFFF, 1'b0, "R1");
    run(10'h389, 32'h0000FFFF, 32'h0000FFFF, 32'h0000FFFF, 32'h00000000, 1'b0, "R1");

    // R1..R8 random sweep against the lane model
    for (int i = 0; i < 3000; i++) begin
      logic [9:0]  o = 10'h380 + 10'($urandom_range(0, 15));
      logic [31:0] a = {pick16(), pick16()};
      logic [31:0] b = {pick16(), pick16()};
      logic [31:0] c = {pick16(), pick16()};
      logic        e_ill = (o > 10'h38D);
      logic [31:0] exp = e_ill ? 32'h0 :
        {ref_lane(o, a[31:16], b[31:16], c[31:16]), ref_lane(o, a[15:0], b[15:0], c[15:0])};
      run(o, a, b, c, exp, e_ill, (i % 2 == 0) ? "R1" : req_of(o));
    end

    // R9: asynchronous reset mid-run clears outputs without a clock edge
    @(negedge clk);
    op = 10'h38E;
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1 chk("R9", {31'b0, ill}, 32'h0);
    chk("R9", res, 32'h0);
    finish_run();
  end
endmodule